// File: doc/BRIEF.md
# Vertical Clock Pulse Pattern Generator

This block drives a bank of vertical clock lines for an image-sensor timing generator. A pattern group gives each line a starting level and a small set of toggle positions. A start strobe launches the group. From that point a position counter walks through the pattern, and every line inverts when the counter matches one of its enabled toggle positions. The pattern repeats when the counter passes a programmed repeat limit.

There are two resolutions. In normal mode the position counter advances once per pixel clock, so toggles land on single pixels. In multiplier mode a prescaler of programmable length divides the counter. A toggle position T then lands on pixel T × length, which gives very wide pulses at a coarser placement step. Without sweep, a line-sync pulse restarts the group. With sweep enabled, line syncs are ignored, so pulses can run across line boundaries.

Top module: `vpulse_gen`

## Requirements
- R1: After reset every output is 0. The outputs stay 0 (line sync included) until the first start strobe is sampled.
- R2: On the clock edge that samples `start` high, every output takes its `start_pol` bit. Pixel 0 of the group ends at the next edge.
- R3: With `multi_en` = 0, an output with an enabled toggle value T inverts on the (T+1)-th edge after the restart edge. For example, toggles 2 and 9 give inversions at pixels 2 and 9.
- R4: With `multi_en` = 1 and `vlen` ≥ 2, a toggle value T inverts its output at pixel T × `vlen`, which is the (T×`vlen`+1)-th edge. Outputs change only on pixels that are multiples of `vlen`. For example, `vlen` = 4 with toggles 2 and 9 gives pixels 8 and 36.
- R5: With `multi_en` = 1 and `vlen` equal to 0 or 1, the block behaves exactly as in normal mode.
- R6: A toggle value of 0 inverts its output on the first edge after the restart edge.
- R7: Toggle slot k of output i is `tog_pos[(i*NUM_TOG+k)*POS_W +: POS_W]` and is enabled by `tog_en[i*NUM_TOG+k]`. A disabled slot has no effect. Several enabled slots holding the same value produce a single inversion.
- R8: After the position counter has reached `vrep` and its prescale period ends, the counter returns to 0. The pattern then repeats every (`vrep`+1) × divisor pixels, where the divisor is 1 in normal mode. A toggle value above `vrep` is never reached.
- R9: With `sweep_en` = 0 and a group running, a sampled `hd` restores `start_pol` on that edge and restarts counting as in R2.
- R10: With `sweep_en` = 1, `hd` has no effect and counting continues across lines.
- R11: A start strobe while a group is running restarts the group as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pattern group launch strobe |
| hd | input | 1 | Line sync pulse |
| multi_en | input | 1 | 1 selects multiplier (coarse) mode |
| sweep_en | input | 1 | 1 lets pulses run across line syncs |
| vlen | input | POS_W | Prescale length used as multiplier factor |
| vrep | input | POS_W | Highest position before the counter wraps |
| start_pol | input | NUM_OUT | Starting level of each output |
| tog_pos | input | NUM_OUT*NUM_TOG*POS_W | Packed toggle positions, slot order per R7 |
| tog_en | input | NUM_OUT*NUM_TOG | Per-slot enables |
| xv | output | NUM_OUT | Vertical clock outputs |

## Verification
Every output is registered, so the result of a strobe, a line sync or a toggle match shows one rising edge after the edge that samples it. The bench counts the edges it has itself issued since the last restart (n). It predicts the level of each output from the parity of the toggle hits at pixels T × divisor (modulo the repeat period) that fall within n. It drives its inputs on the falling edge and compares all outputs on the following falling edge, half a cycle after the edge that updated them. The configuration is changed only in the cycle that carries a start strobe, so no prediction depends on a setting that was changed partway through a pattern.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

   localparam int VPG_MAX_W = 16;

   typedef enum logic {
      VPG_IDLE = 1'b0,
      VPG_RUN  = 1'b1
   } vpg_state_e;

   // Prescale divisor actually applied: 1 unless coarse mode has a length of 2 or more.
   function automatic logic [VPG_MAX_W-1:0] eff_div(input logic multi,
                                                   input logic [VPG_MAX_W-1:0] len);
      if (multi && (len > 16'd1))
         return len;
      return 16'd1;
   endfunction

endpackage

// File: rtl/vpg_prescale.sv
module vpg_prescale #(
   parameter int POS_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [POS_W-1:0] div,
   output logic             phase0,
   output logic             adv
);

   logic [POS_W-1:0] ph_q;
   logic [POS_W-1:0] last_ph;

   assign last_ph = div - POS_W'(1);
   assign phase0  = (ph_q == '0);
   assign adv     = (ph_q >= last_ph);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_q <= '0;
      else if (restart)
         ph_q <= '0;
      else if (run)
         ph_q <= adv ? '0 : ph_q + POS_W'(1);
   end

endmodule

// File: rtl/vpg_poscount.sv
module vpg_poscount #(
   parameter int POS_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic             adv,
   input  logic [POS_W-1:0] vrep,
   output logic [POS_W-1:0] pos
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos <= '0;
      else if (restart)
         pos <= '0;
      else if (run && adv)
         pos <= (pos == vrep) ? '0 : pos + POS_W'(1);
   end

endmodule

// File: rtl/vpg_lane.sv
module vpg_lane #(
   parameter int POS_W   = 13,
   parameter int NUM_TOG = 4,
   localparam int TOG_BITS = NUM_TOG * POS_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                run,
   input  logic                phase0,
   input  logic [POS_W-1:0]    pos,
   input  logic                pol,
   input  logic [TOG_BITS-1:0] tog,
   input  logic [NUM_TOG-1:0]  en,
   output logic                q
);

   logic [NUM_TOG-1:0] match;

   for (genvar k = 0; k < NUM_TOG; k++) begin : g_slot
      assign match[k] = en[k] && (tog[k*POS_W +: POS_W] == pos);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (restart)
         q <= pol;
      else if (run && phase0 && (|match))
         q <= ~q;
   end

endmodule

// File: rtl/vpulse_gen.sv
module vpulse_gen #(
   parameter int NUM_OUT      = 10,
   parameter int NUM_TOG      = 4,
   parameter int POS_W        = 13,
   parameter bit MULT_SUPPORT = 1'b1,
   localparam int SLOTS    = NUM_OUT * NUM_TOG,
   localparam int TOG_BITS = NUM_TOG * POS_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     hd,
   input  logic                     multi_en,
   input  logic                     sweep_en,
   input  logic [POS_W-1:0]         vlen,
   input  logic [POS_W-1:0]         vrep,
   input  logic [NUM_OUT-1:0]       start_pol,
   input  logic [SLOTS*POS_W-1:0]   tog_pos,
   input  logic [SLOTS-1:0]         tog_en,
   output logic [NUM_OUT-1:0]       xv
);
   import vpg_pkg::*;

   if (NUM_OUT < 1 || NUM_OUT > 32) begin : g_bad_out
      $error("vpulse_gen: NUM_OUT must be 1..32");
   end
   if (NUM_TOG < 1 || NUM_TOG > 8) begin : g_bad_tog
      $error("vpulse_gen: NUM_TOG must be 1..8");
   end
   if (POS_W < 2 || POS_W > VPG_MAX_W) begin : g_bad_w
      $error("vpulse_gen: POS_W must be 2..16");
   end

   vpg_state_e       state_q;
   logic             restart;
   logic             run;
   logic             phase0;
   logic             adv;
   logic [POS_W-1:0] pos;

   assign restart = start | (hd & ~sweep_en & (state_q == VPG_RUN));
   assign run     = (state_q == VPG_RUN) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= VPG_IDLE;
      else if (start)
         state_q <= VPG_RUN;
   end

   if (MULT_SUPPORT) begin : g_mult
      logic [VPG_MAX_W-1:0] div_w;
      assign div_w = eff_div(multi_en, VPG_MAX_W'(vlen));

      vpg_prescale #(.POS_W(POS_W)) u_pre (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (restart),
         .run     (run),
         .div     (div_w[POS_W-1:0]),
         .phase0  (phase0),
         .adv     (adv)
      );
   end else begin : g_plain
      assign phase0 = 1'b1;
      assign adv    = 1'b1;
   end

   vpg_poscount #(.POS_W(POS_W)) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .run     (run),
      .adv     (adv),
      .vrep    (vrep),
      .pos     (pos)
   );

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
      vpg_lane #(.POS_W(POS_W), .NUM_TOG(NUM_TOG)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (restart),
         .run     (run),
         .phase0  (phase0),
         .pos     (pos),
         .pol     (start_pol[i]),
         .tog     (tog_pos[i*TOG_BITS +: TOG_BITS]),
         .en      (tog_en[i*NUM_TOG +: NUM_TOG]),
         .q       (xv[i])
      );
   end

endmodule

// File: rtl/vpulse_gen_chk.sv
module vpulse_gen_chk #(
   parameter int NUM_OUT = 10,
   parameter int POS_W   = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               hd,
   input logic               multi_en,
   input logic               sweep_en,
   input logic [POS_W-1:0]   vlen,
   input logic [NUM_OUT-1:0] start_pol,
   input logic [NUM_OUT-1:0] xv
);

   logic        seen_q;
   logic [31:0] since_q;
   logic        line_rst;
   logic [31:0] vl32;

   assign line_rst = hd && !sweep_en && seen_q;
   assign vl32     = 32'(vlen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b0;
         since_q <= '0;
      end else begin
         if (start)
            seen_q <= 1'b1;
         if (start || line_rst)
            since_q <= '0;
         else if (seen_q && since_q != 32'hFFFF_FFFF)
            since_q <= since_q + 32'd1;
      end
   end

   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> (xv == '0));

   assert_start_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (xv == $past(start_pol)));

   assert_line_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hd && !sweep_en && seen_q && !start) |=> (xv == $past(start_pol)));

   assert_coarse_grid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !start && !line_rst && multi_en && vlen > POS_W'(1)
       && (since_q % vl32) != 32'd0) |=> $stable(xv));

endmodule

bind vpulse_gen vpulse_gen_chk #(.NUM_OUT(NUM_OUT), .POS_W(POS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .hd        (hd),
   .multi_en  (multi_en),
   .sweep_en  (sweep_en),
   .vlen      (vlen),
   .start_pol (start_pol),
   .xv        (xv)
);

// File: tb/vpulse_gen_bench.sv
module vpulse_gen_bench;
   localparam int NO  = 10;
   localparam int NT  = 4;
   localparam int PW  = 13;
   localparam int CYC = 10;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic                 hd = 1'b0;
   logic                 multi_en = 1'b0;
   logic                 sweep_en = 1'b0;
   logic [PW-1:0]        vlen = '0;
   logic [PW-1:0]        vrep = '0;
   logic [NO-1:0]        start_pol = '0;
   logic [NO*NT*PW-1:0]  tog_pos = '0;
   logic [NO*NT-1:0]     tog_en = '0;
   logic [NO-1:0]        xv;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  act_m = 1'b0;
   int  m_edges = 0;
   bit  done = 1'b0;

   always #(CYC/2) clk = ~clk;

   vpulse_gen u_vpulse_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .hd(hd),
      .multi_en(multi_en), .sweep_en(sweep_en), .vlen(vlen), .vrep(vrep),
      .start_pol(start_pol), .tog_pos(tog_pos), .tog_en(tog_en), .xv(xv)
   );

   function automatic int slot_val(int i, int k);
      return int'(tog_pos[(i*NT+k)*PW +: PW]);
   endfunction

   function automatic logic exp_bit(int i);
      int v, l, flips, t;
      bit dup;
      if (!act_m) return 1'b0;
      v = (multi_en && vlen > 1) ? int'(vlen) : 1;
      l = (int'(vrep) + 1) * v;
      flips = 0;
      for (int k = 0; k < NT; k++) begin
         t = slot_val(i, k);
         if (tog_en[i*NT+k] && t <= int'(vrep)) begin
            dup = 1'b0;
            for (int j = 0; j < k; j++)
               if (tog_en[i*NT+j] && slot_val(i, j) == t) dup = 1'b1;
            if (!dup && (m_edges - 1) >= t * v)
               flips += (m_edges - 1 - t * v) / l + 1;
         end
      end
      return start_pol[i] ^ flips[0];
   endfunction

   function automatic logic [NO-1:0] exp_vec();
      logic [NO-1:0] e;
      for (int i = 0; i < NO; i++) e[i] = exp_bit(i);
      return e;
   endfunction

   task automatic check(string tag);
      logic [NO-1:0] e;
      e = exp_vec();
      n_chk++;
      if (xv !== e) begin
         n_bad++;
         $display("FAIL %s: xv=%b expected %b (edges=%0d)", tag, xv, e, m_edges);
      end
   endtask

   // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge.
   task automatic step(bit s, bit h, string tag);
      start = s;
      hd    = h;
      @(posedge clk);
      if (s) begin
         act_m = 1'b1; m_edges = 0;
      end else if (h && !sweep_en && act_m) begin
         m_edges = 0;
      end else if (act_m) begin
         m_edges++;
      end
      @(negedge clk);
      start = 1'b0;
      hd    = 1'b0;
      check(tag);
   endtask

   task automatic clear_cfg();
      tog_en    = '0;
      tog_pos   = '0;
      start_pol = '0;
   endtask

   task automatic set_slot(int i, int k, int val, bit en);
      tog_pos[(i*NT+k)*PW +: PW] = PW'(val);
      tog_en[i*NT+k] = en;
   endtask

   task automatic run_group(int n, int hd_pct, string tag);
      step(1'b1, 1'b0, "R2");
      for (int c = 0; c < n; c++)
         step(1'b0, (hd_pct > 0) && (($urandom % 100) < hd_pct), tag);
   endtask

   initial begin
      #(CYC * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");
      // R1: line syncs before any start leave outputs low
      start_pol = '1;
      for (int c = 0; c < 5; c++) step(1'b0, 1'b1, "R1");

      // R3: normal mode, toggles 2 and 9
      clear_cfg();
      multi_en = 0; sweep_en = 1; vlen = 13'd4; vrep = 13'd40;
      set_slot(0, 0, 2, 1); set_slot(0, 1, 9, 1); start_pol[1] = 1'b1;
      run_group(15, 0, "R3");

      // R4: multiplier example, toggles at pixels 8 and 36, wrap after pixel 39
      multi_en = 1; vrep = 13'd9;
      run_group(50, 0, "R4");

      // R5: length 1 and 0 in multiplier mode act as normal mode
      vlen = 13'd1; vrep = 13'd40;
      run_group(14, 0, "R5");
      vlen = 13'd0;
      run_group(14, 0, "R5");

      // R6: toggle at zero
      clear_cfg();
      multi_en = 0; vrep = 13'd20;
      set_slot(3, 0, 0, 1); set_slot(3, 1, 4, 1);
      run_group(8, 0, "R6");
      multi_en = 1; vlen = 13'd3;
      run_group(8, 0, "R6");

      // R7: duplicate slots and disabled slot
      clear_cfg();
      multi_en = 0; vrep = 13'd20;
      set_slot(2, 0, 5, 1); set_slot(2, 1, 5, 1); set_slot(2, 2, 7, 0); set_slot(2, 3, 3, 1);
      start_pol[2] = 1'b1;
      run_group(12, 0, "R7");

      // R8: repeat limit
      clear_cfg();
      vrep = 13'd5;
      set_slot(4, 0, 1, 1); set_slot(4, 1, 5, 1); set_slot(5, 0, 9, 1);
      run_group(20, 0, "R8");
      multi_en = 1; vlen = 13'd3; vrep = 13'd4;
      set_slot(6, 0, 2, 1);
      run_group(40, 0, "R8");

      // R9: line sync restarts when sweep is off
      sweep_en = 0;
      run_group(6, 0, "R9");
      step(1'b0, 1'b1, "R9");
      for (int c = 0; c < 10; c++) step(1'b0, 1'b0, "R9");

      // R10: line sync ignored with sweep on
      sweep_en = 1;
      run_group(4, 0, "R10");
      for (int c = 0; c < 20; c++) step(1'b0, (c % 3) == 0, "R10");

      // R11: restart mid-run
      run_group(7, 0, "R11");
      step(1'b1, 1'b0, "R11");
      for (int c = 0; c < 12; c++) step(1'b0, 1'b0, "R11");

      // Constrained random groups
      for (int s = 0; s < 40; s++) begin
         multi_en  = ($urandom % 2) == 1;
         sweep_en  = ($urandom % 2) == 1;
         vlen      = PW'($urandom % 6);
         vrep      = PW'($urandom % 13);
         start_pol = NO'($urandom);
         for (int i = 0; i < NO; i++)
            for (int k = 0; k < NT; k++)
               set_slot(i, k, int'($urandom % 15), ($urandom % 4) != 0);
         run_group(int'((vrep + 1) * ((vlen > 1) ? vlen : 1)) * 2 + 3, 4,
                   multi_en ? "R4" : "R3");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule